// File: doc/BRIEF.md
# CAN Transmit Mailbox Manager

This block holds a small set of outgoing CAN frames on behalf of a host and passes them, one mailbox at a time, to a bus-side transmitter. The host offers a frame with its identifier, extended and remote flags, length, eight data bytes, a deadline and two option flags. The frame is placed in the lowest-numbered free mailbox. The identifier word is packed there, and the transmit request is raised one cycle after the rest of the mailbox is filled. A separate candidate port reports whether a frame would be allowed in now. The answer follows bus arbitration priority, so a lower-priority frame cannot get ahead of the frames already waiting.

The bus side reports completion for each mailbox with a done strobe and a success flag. On success the block counts the frame once and, if the host asked for it, returns a copy through a loopback output. Copies from several mailboxes leave in mailbox order. A mailbox whose deadline has passed gets an abort request and is counted as a timeout. A nonzero last-error code from the bus is acknowledged at once, and it aborts every waiting mailbox whose frame asked to be aborted on error.

Top module: `can_txmb_mgr`

## Requirements
- R1: After reset no mailbox is occupied, `mb_req` and `mb_abort` are zero, all counters are zero, `lb_valid` is low and `can_accept` is high.
- R2: A valid push goes into the lowest-indexed free mailbox, and `push_ack` is high with `push_slot` giving that index. When every mailbox is occupied, `push_ack` is low.
- R3: The identifier word is laid out as follows. A standard frame has the 11-bit identifier in bits 31:21 and zeros in bits 20:3. An extended frame has the 29-bit identifier in bits 31:3. Bit 2 is the extended flag, bit 1 the remote flag and bit 0 the transmit request.
- R4: In the cycle after the push, the mailbox shows its identifier word, length and data with bit 0 and `mb_req` low. One cycle later `mb_req` and bit 0 are high.
- R5: A push flagged as an error frame, or with a length above 8, gets `push_ack` low and occupies no mailbox.
- R6: `can_accept` is high when all mailboxes are free and low when none is free. Otherwise it is high only if the candidate key is strictly lower than the key of every waiting mailbox. For a standard frame the key is {id[10:0], remote, 0, 19 zeros}. For an extended frame it is {id[28:18], 1, 1, id[17:0], remote}.
- R7: A done strobe frees the mailbox. The success counter rises by one only when the done strobe comes with the success flag set.
- R8: A successful frame with loopback requested appears on `lb_valid`/`lb_*` with bit 0 cleared, starting the cycle after completion. Frames that complete in the same cycle appear on consecutive cycles in mailbox order 0, 1, 2.
- R9: A waiting mailbox whose deadline is less than `now` drops `mb_req`, raises `mb_abort` until its done strobe, and adds exactly one to the timeout counter.
- R10: A nonzero `bus_lec` raises `lec_clear` in the same cycle. Every waiting mailbox flagged abort-on-error moves to abort, and each one adds one to the error-abort counter.
- R11: Aborted mailboxes are left out of the priority comparison in `can_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Host offers a frame this cycle |
| push_id | input | 29 | Identifier (low 11 bits used for standard frames) |
| push_ext | input | 1 | Extended identifier flag |
| push_rtr | input | 1 | Remote frame flag |
| push_err | input | 1 | Frame is an error frame (always refused) |
| push_dlc | input | 4 | Data length code |
| push_data | input | 64 | Data bytes |
| push_deadline | input | TIME_W | Time after which the frame is abandoned |
| push_loopback | input | 1 | Return a copy on success |
| push_abort_on_err | input | 1 | Abort this frame on a bus error |
| push_ack | output | 1 | Push taken this cycle |
| push_slot | output | SLOT_W | Mailbox chosen for the push |
| cand_id | input | 29 | Identifier of the frame being asked about |
| cand_ext | input | 1 | Extended flag of the candidate |
| cand_rtr | input | 1 | Remote flag of the candidate |
| can_accept | output | 1 | Candidate frame may be pushed now |
| now | input | TIME_W | Current time |
| bus_lec | input | 3 | Last error code from the bus side |
| lec_clear | output | 1 | Clears the bus error code |
| mb_req | output | NUM_MB | Transmit request for each mailbox |
| mb_abort | output | NUM_MB | Abort request for each mailbox |
| mb_done | input | NUM_MB | Bus side finished with a mailbox |
| mb_txok | input | NUM_MB | Finished mailbox was sent successfully |
| mb_idword | output | 32*NUM_MB | Identifier word of each mailbox |
| mb_dlc | output | 4*NUM_MB | Length of each mailbox |
| mb_data | output | 64*NUM_MB | Data of each mailbox |
| lb_valid | output | 1 | Loopback item present |
| lb_idword | output | 32 | Loopback identifier word |
| lb_dlc | output | 4 | Loopback length |
| lb_data | output | 64 | Loopback data |
| cnt_success | output | CNT_W | Frames sent successfully |
| cnt_timeout | output | CNT_W | Mailboxes aborted on deadline |
| cnt_abort | output | CNT_W | Mailboxes aborted on bus error |

## Verification
The bench builds the block with three mailboxes, an 8-bit time base, 8-bit counters and a four-entry loopback queue. The narrow time base keeps deadlines and `now` small enough to place the deadline crossing on an exact cycle. The 8-bit success counter wraps during the random phase, so modulo counting is exercised. Three mailboxes let the bench fill every slot and test the full, partly free and all-free acceptance cases. With a four-entry queue, three same-cycle completions fit in the queue and still have to leave in index order.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

   typedef enum logic [1:0] {
      SL_FREE  = 2'd0,
      SL_LOAD  = 2'd1,
      SL_PEND  = 2'd2,
      SL_ABORT = 2'd3
   } slot_st_e;

   typedef struct packed {
      logic [31:0] idword;
      logic [3:0]  dlc;
      logic [63:0] data;
   } rx_item_t;

   // Identifier word: bit2 extended, bit1 remote, bit0 transmit request (left 0 here).
   function automatic logic [31:0] pack_idword(input logic [28:0] id,
                                               input logic ext,
                                               input logic rtr);
      logic [31:0] w;
      if (ext) w = {id, 3'b100};
      else     w = {id[10:0], 21'd0};
      w[1] = rtr;
      return w;
   endfunction

   // Arbitration key in bus bit order; lower value wins.
   function automatic logic [31:0] arb_key(input logic [31:0] w);
      if (w[2]) return {w[31:21], 1'b1, 1'b1, w[20:3], w[1]};
      else      return {w[31:21], w[1], 1'b0, 19'd0};
   endfunction

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
   import can_txmb_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [31:0]       load_idword,
   input  logic [3:0]        load_dlc,
   input  logic [63:0]       load_data,
   input  logic [TIME_W-1:0] load_deadline,
   input  logic              load_loop,
   input  logic              load_aoe,
   input  logic [TIME_W-1:0] now,
   input  logic              lec_evt,
   input  logic              done,
   input  logic              txok,
   output logic              occupied,
   output logic              pending,
   output logic              req,
   output logic              abort_req,
   output logic [31:0]       idword,
   output logic [3:0]        dlc,
   output logic [63:0]       data,
   output logic [31:0]       key,
   output logic              ev_success,
   output logic              ev_timeout,
   output logic              ev_errabort,
   output logic              ev_loop
);

   slot_st_e          st_q, st_n;
   logic [31:0]       idw_q;
   logic [3:0]        dlc_q;
   logic [63:0]       data_q;
   logic [TIME_W-1:0] dl_q;
   logic              loop_q;
   logic              aoe_q;
   logic              expired;
   logic              err_hit;

   assign expired = (dl_q < now);
   assign err_hit = lec_evt & aoe_q;

   always_comb begin
      st_n        = st_q;
      ev_success  = 1'b0;
      ev_timeout  = 1'b0;
      ev_errabort = 1'b0;
      ev_loop     = 1'b0;
      unique case (st_q)
         SL_FREE: begin
            if (load) st_n = SL_LOAD;
         end
         SL_LOAD: begin
            if (expired) begin
               st_n       = SL_FREE;
               ev_timeout = 1'b1;
            end else if (err_hit) begin
               st_n        = SL_FREE;
               ev_errabort = 1'b1;
            end else begin
               st_n = SL_PEND;
            end
         end
         SL_PEND: begin
            if (done) begin
               st_n       = SL_FREE;
               ev_success = txok;
               ev_loop    = txok & loop_q;
            end else if (expired) begin
               st_n       = SL_ABORT;
               ev_timeout = 1'b1;
            end else if (err_hit) begin
               st_n        = SL_ABORT;
               ev_errabort = 1'b1;
            end
         end
         SL_ABORT: begin
            if (done) begin
               st_n       = SL_FREE;
               ev_success = txok;
               ev_loop    = txok & loop_q;
            end
         end
         default: st_n = SL_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SL_FREE;
      else        st_q <= st_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idw_q  <= '0;
         dlc_q  <= '0;
         data_q <= '0;
         dl_q   <= '0;
         loop_q <= 1'b0;
         aoe_q  <= 1'b0;
      end else if (st_q == SL_FREE && load) begin
         idw_q  <= load_idword;
         dlc_q  <= load_dlc;
         data_q <= load_data;
         dl_q   <= load_deadline;
         loop_q <= load_loop;
         aoe_q  <= load_aoe;
      end
   end

   assign occupied  = (st_q != SL_FREE);
   assign pending   = (st_q == SL_LOAD) || (st_q == SL_PEND);
   assign req       = (st_q == SL_PEND);
   assign abort_req = (st_q == SL_ABORT);
   assign idword    = idw_q | {31'd0, req};
   assign dlc       = dlc_q;
   assign data      = data_q;
   assign key       = arb_key(idw_q);

endmodule

// File: rtl/can_txmb_sel.sv
module can_txmb_sel #(
   parameter int NUM_MB = 3,
   parameter int SW     = 2
) (
   input  logic [NUM_MB-1:0]    occ,
   input  logic [NUM_MB-1:0]    pend,
   input  logic [NUM_MB*32-1:0] keys,
   input  logic [31:0]          cand_key,
   output logic                 free_any,
   output logic [SW-1:0]        free_idx,
   output logic                 accept
);

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = NUM_MB - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            free_any = 1'b1;
            free_idx = SW'(i);
         end
      end
   end

   always_comb begin
      if (occ == '0) begin
         accept = 1'b1;
      end else if (&occ) begin
         accept = 1'b0;
      end else begin
         accept = 1'b1;
         for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i] && !(cand_key < keys[i*32 +: 32])) accept = 1'b0;
         end
      end
   end

endmodule

// File: rtl/can_txmb_lbq.sv
module can_txmb_lbq
   import can_txmb_pkg::*;
#(
   parameter int NUM_MB = 3,
   parameter int DEPTH  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [NUM_MB-1:0] ev,
   input  rx_item_t    items [NUM_MB],
   output logic        lb_valid,
   output rx_item_t    lb_item
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CW    = PTR_W + 1;

   rx_item_t         mem [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [CW-1:0]    cnt_q;
   logic             pop;
   int               base_i;
   int               nw;
   logic [NUM_MB-1:0] wen;
   logic [PTR_W-1:0] wpos [NUM_MB];

   always_comb begin
      pop    = (cnt_q != '0);
      base_i = int'(cnt_q) - (pop ? 1 : 0);
      nw     = 0;
      for (int k = 0; k < NUM_MB; k++) begin
         wen[k]  = 1'b0;
         wpos[k] = wr_q;
         if (ev[k] && (base_i + nw) < DEPTH) begin
            wen[k]  = 1'b1;
            wpos[k] = wr_q + PTR_W'(nw);
            nw      = nw + 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         rd_q  <= rd_q + PTR_W'(pop);
         wr_q  <= wr_q + PTR_W'(nw);
         cnt_q <= CW'(base_i + nw);
      end
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < NUM_MB; k++) begin
         if (wen[k]) mem[wpos[k]] <= items[k];
      end
   end

   assign lb_valid = (cnt_q != '0);
   assign lb_item  = mem[rd_q];

endmodule

// File: rtl/can_txmb_mgr.sv
module can_txmb_mgr
   import can_txmb_pkg::*;
#(
   parameter int NUM_MB   = 3,
   parameter int TIME_W   = 16,
   parameter int CNT_W    = 16,
   parameter int LB_DEPTH = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push_valid,
   input  logic [28:0]             push_id,
   input  logic                    push_ext,
   input  logic                    push_rtr,
   input  logic                    push_err,
   input  logic [3:0]              push_dlc,
   input  logic [63:0]             push_data,
   input  logic [TIME_W-1:0]       push_deadline,
   input  logic                    push_loopback,
   input  logic                    push_abort_on_err,
   output logic                    push_ack,
   output logic [((NUM_MB > 1) ? $clog2(NUM_MB) : 1)-1:0] push_slot,
   input  logic [28:0]             cand_id,
   input  logic                    cand_ext,
   input  logic                    cand_rtr,
   output logic                    can_accept,
   input  logic [TIME_W-1:0]       now,
   input  logic [2:0]              bus_lec,
   output logic                    lec_clear,
   output logic [NUM_MB-1:0]       mb_req,
   output logic [NUM_MB-1:0]       mb_abort,
   input  logic [NUM_MB-1:0]       mb_done,
   input  logic [NUM_MB-1:0]       mb_txok,
   output logic [NUM_MB*32-1:0]    mb_idword,
   output logic [NUM_MB*4-1:0]     mb_dlc,
   output logic [NUM_MB*64-1:0]    mb_data,
   output logic                    lb_valid,
   output logic [31:0]             lb_idword,
   output logic [3:0]              lb_dlc,
   output logic [63:0]             lb_data,
   output logic [CNT_W-1:0]        cnt_success,
   output logic [CNT_W-1:0]        cnt_timeout,
   output logic [CNT_W-1:0]        cnt_abort
);

   localparam int SLOT_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;

   if (NUM_MB < 1 || NUM_MB > 8) begin : g_bad_mb
      $error("can_txmb_mgr: NUM_MB must be 1..8");
   end
   if (LB_DEPTH < NUM_MB || LB_DEPTH < 2 || (LB_DEPTH & (LB_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("can_txmb_mgr: LB_DEPTH must be a power of two >= NUM_MB and >= 2");
   end
   if (TIME_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("can_txmb_mgr: TIME_W and CNT_W must be positive");
   end

   logic [NUM_MB-1:0]    slot_occ;
   logic [NUM_MB-1:0]    slot_pend;
   logic [NUM_MB*32-1:0] slot_key;
   logic [NUM_MB-1:0]    ev_succ, ev_tmo, ev_err, ev_loop;
   rx_item_t             lb_items [NUM_MB];
   rx_item_t             lb_head;
   logic                 free_any;
   logic [SLOT_W-1:0]    free_idx;
   logic                 frame_ok;
   logic                 lec_evt;
   logic [31:0]          push_word;

   assign lec_evt   = (bus_lec != 3'd0);
   assign lec_clear = lec_evt;
   assign frame_ok  = !push_err && (push_dlc <= 4'd8);
   assign push_ack  = push_valid && frame_ok && free_any;
   assign push_slot = free_idx;
   assign push_word = pack_idword(push_id, push_ext, push_rtr);

   for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
      logic [31:0] w;
      logic [3:0]  d;
      logic [63:0] p;
      can_txmb_slot #(.TIME_W(TIME_W)) u_slot (
         .clk           (clk),
         .rst_n         (rst_n),
         .load          (push_ack && (free_idx == SLOT_W'(i))),
         .load_idword   (push_word),
         .load_dlc      (push_dlc),
         .load_data     (push_data),
         .load_deadline (push_deadline),
         .load_loop     (push_loopback),
         .load_aoe      (push_abort_on_err),
         .now           (now),
         .lec_evt       (lec_evt),
         .done          (mb_done[i]),
         .txok          (mb_txok[i]),
         .occupied      (slot_occ[i]),
         .pending       (slot_pend[i]),
         .req           (mb_req[i]),
         .abort_req     (mb_abort[i]),
         .idword        (w),
         .dlc           (d),
         .data          (p),
         .key           (slot_key[i*32 +: 32]),
         .ev_success    (ev_succ[i]),
         .ev_timeout    (ev_tmo[i]),
         .ev_errabort   (ev_err[i]),
         .ev_loop       (ev_loop[i])
      );
      assign mb_idword[i*32 +: 32] = w;
      assign mb_dlc[i*4 +: 4]      = d;
      assign mb_data[i*64 +: 64]   = p;
      assign lb_items[i]           = '{idword: {w[31:1], 1'b0}, dlc: d, data: p};
   end

   can_txmb_sel #(.NUM_MB(NUM_MB), .SW(SLOT_W)) u_sel (
      .occ      (slot_occ),
      .pend     (slot_pend),
      .keys     (slot_key),
      .cand_key (arb_key(pack_idword(cand_id, cand_ext, cand_rtr))),
      .free_any (free_any),
      .free_idx (free_idx),
      .accept   (can_accept)
   );

   can_txmb_lbq #(.NUM_MB(NUM_MB), .DEPTH(LB_DEPTH)) u_lbq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_loop),
      .items    (lb_items),
      .lb_valid (lb_valid),
      .lb_item  (lb_head)
   );

   assign lb_idword = lb_head.idword;
   assign lb_dlc    = lb_head.dlc;
   assign lb_data   = lb_head.data;

   int n_succ, n_tmo, n_err;
   always_comb begin
      n_succ = 0;
      n_tmo  = 0;
      n_err  = 0;
      for (int i = 0; i < NUM_MB; i++) begin
         n_succ = n_succ + (ev_succ[i] ? 1 : 0);
         n_tmo  = n_tmo  + (ev_tmo[i]  ? 1 : 0);
         n_err  = n_err  + (ev_err[i]  ? 1 : 0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_success <= '0;
         cnt_timeout <= '0;
         cnt_abort   <= '0;
      end else begin
         cnt_success <= cnt_success + CNT_W'(n_succ);
         cnt_timeout <= cnt_timeout + CNT_W'(n_tmo);
         cnt_abort   <= cnt_abort + CNT_W'(n_err);
      end
   end

endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk #(
   parameter int NUM_MB = 3,
   parameter int CNT_W  = 16,
   parameter int SW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic              push_err,
   input logic [3:0]        push_dlc,
   input logic              push_ack,
   input logic [SW-1:0]     push_slot,
   input logic [NUM_MB-1:0] slot_occ,
   input logic              can_accept,
   input logic [NUM_MB-1:0] mb_req,
   input logic [NUM_MB-1:0] mb_abort,
   input logic [NUM_MB-1:0] mb_done,
   input logic [NUM_MB-1:0] mb_txok,
   input logic [CNT_W-1:0]  cnt_success,
   input logic [CNT_W-1:0]  cnt_timeout,
   input logic              lb_valid
);

   p_full_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&slot_occ) |-> (!push_ack && !can_accept));

   p_empty_accepts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_occ == '0) |-> can_accept);

   p_bad_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && (push_err || push_dlc > 4'd8)) |-> !push_ack);

   p_req_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_ack |=> ((mb_req >> $past(push_slot)) & {{(NUM_MB-1){1'b0}}, 1'b1}) == '0);

   p_req_abort_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_req & mb_abort) == '0);

   p_success_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_success) |-> $past((mb_done & mb_txok) != '0));

   p_timeout_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_timeout) |-> $past(slot_occ != '0));

   p_loop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lb_valid) |-> $past((mb_done & mb_txok) != '0));

endmodule

bind can_txmb_mgr can_txmb_chk #(.NUM_MB(NUM_MB), .CNT_W(CNT_W), .SW(SLOT_W)) u_chk (.*);

// File: tb/can_txmb_mgr_test.sv
module can_txmb_mgr_test;

   localparam int NUM_MB   = 3;
   localparam int TIME_W   = 8;
   localparam int CNT_W    = 8;
   localparam int LB_DEPTH = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push_valid = 1'b0;
   logic [28:0]       push_id = '0;
   logic              push_ext = 1'b0;
   logic              push_rtr = 1'b0;
   logic              push_err = 1'b0;
   logic [3:0]        push_dlc = '0;
   logic [63:0]       push_data = '0;
   logic [TIME_W-1:0] push_deadline = '0;
   logic              push_loopback = 1'b0;
   logic              push_abort_on_err = 1'b0;
   logic              push_ack;
   logic [1:0]        push_slot;
   logic [28:0]       cand_id = '0;
   logic              cand_ext = 1'b0;
   logic              cand_rtr = 1'b0;
   logic              can_accept;
   logic [TIME_W-1:0] now = '0;
   logic [2:0]        bus_lec = '0;
   logic              lec_clear;
   logic [NUM_MB-1:0] mb_req, mb_abort;
   logic [NUM_MB-1:0] mb_done = '0;
   logic [NUM_MB-1:0] mb_txok = '0;
   logic [NUM_MB*32-1:0] mb_idword;
   logic [NUM_MB*4-1:0]  mb_dlc;
   logic [NUM_MB*64-1:0] mb_data;
   logic              lb_valid;
   logic [31:0]       lb_idword;
   logic [3:0]        lb_dlc;
   logic [63:0]       lb_data;
   logic [CNT_W-1:0]  cnt_success, cnt_timeout, cnt_abort;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   can_txmb_mgr #(.NUM_MB(NUM_MB), .TIME_W(TIME_W), .CNT_W(CNT_W), .LB_DEPTH(LB_DEPTH)) uut (.*);

   function automatic logic [31:0] exp_word(logic [28:0] id, logic ext, logic rtr);
      if (ext) return {id, 1'b1, rtr, 1'b0};
      return {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
   endfunction

   function automatic logic [31:0] exp_key(logic [31:0] w);
      if (w[2]) return {w[31:21], 2'b11, w[20:3], w[1]};
      return {w[31:21], w[1], 1'b0, 19'd0};
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push_frame(logic [28:0] id, logic ext, logic rtr, logic err, logic [3:0] dlc,
                             logic [63:0] data, logic [7:0] dl, logic lb, logic aoe,
                             logic exp_ack, logic [1:0] exp_slot, string tag);
      @(negedge clk);
      push_valid = 1'b1; push_id = id; push_ext = ext; push_rtr = rtr; push_err = err;
      push_dlc = dlc; push_data = data; push_deadline = dl; push_loopback = lb;
      push_abort_on_err = aoe;
      #1;
      chk({tag, " ack"}, 64'(push_ack), 64'(exp_ack));
      if (exp_ack) chk({tag, " slot"}, 64'(push_slot), 64'(exp_slot));
      @(posedge clk);
      #1 push_valid = 1'b0; push_err = 1'b0;
   endtask

   task automatic finish_mb(logic [2:0] mask, logic [2:0] ok);
      @(negedge clk);
      mb_done = mask; mb_txok = ok;
      @(posedge clk);
      #1 mb_done = '0; mb_txok = '0;
   endtask

   task automatic probe(logic [28:0] id, logic ext, logic rtr, logic exp, string tag);
      @(negedge clk);
      cand_id = id; cand_ext = ext; cand_rtr = rtr;
      #1 chk(tag, 64'(can_accept), 64'(exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] wa, wc;
      logic [7:0]  succ_exp;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1 req", 64'(mb_req), 0);
      chk("R1 abort", 64'(mb_abort), 0);
      chk("R1 counters", {cnt_success, cnt_timeout, cnt_abort}, 0);
      chk("R1 lb_valid", 64'(lb_valid), 0);
      chk("R1 can_accept", 64'(can_accept), 1);
      chk("R10 lec_clear idle", 64'(lec_clear), 0);

      // R2/R3/R4 load three frames
      wa = exp_word(29'h123, 1'b0, 1'b0);
      push_frame(29'h123, 0, 0, 0, 4'd4, 64'h1111_2222_3333_4444, 8'd200, 1, 0, 1, 0, "R2 A");
      @(negedge clk); #1;
      chk("R3 R4 word A load", 64'(mb_idword[31:0]), 64'(wa));
      chk("R4 req low at load", 64'(mb_req), 0);
      chk("R4 dlc A", 64'(mb_dlc[3:0]), 4);
      push_frame(29'h1ABCDE00, 1, 1, 0, 4'd8, 64'hAA, 8'd20, 0, 0, 1, 1, "R2 B");
      chk("R4 req A", 64'(mb_req[0]), 1);
      chk("R3 word A txrq", 64'(mb_idword[31:0]), 64'(wa | 32'd1));
      @(negedge clk); #1;
      chk("R3 word B ext", 64'(mb_idword[63:32]), 64'(exp_word(29'h1ABCDE00, 1, 1)));
      wc = exp_word(29'h7FF, 1'b0, 1'b0);
      push_frame(29'h7FF, 0, 0, 0, 4'd1, 64'h55, 8'd200, 1, 0, 1, 2, "R2 C");
      push_frame(29'h001, 0, 0, 0, 4'd1, 64'h0, 8'd200, 0, 0, 0, 0, "R2 full");
      probe(29'h000, 0, 0, 0, "R6 none free");

      // R7/R8 slots 0 and 2 finish together
      finish_mb(3'b101, 3'b101);
      @(negedge clk); #1;
      chk("R7 success count", 64'(cnt_success), 2);
      chk("R8 first lb valid", 64'(lb_valid), 1);
      chk("R8 first lb slot0", 64'(lb_idword), 64'(wa));
      chk("R8 first lb data", lb_data, 64'h1111_2222_3333_4444);
      @(negedge clk); #1;
      chk("R8 second lb slot2", 64'(lb_idword), 64'(wc));
      @(negedge clk); #1;
      chk("R8 queue drained", 64'(lb_valid), 0);
      chk("R7 slots freed", 64'(mb_req), 64'(3'b010));

      // R6 ordering against pending extended remote frame B
      probe(29'h6AF, 0, 0, 1, "R6 std wins tie");
      probe(29'h6B0, 0, 0, 0, "R6 std lower priority");
      probe(29'h1ABCDE00, 1, 0, 1, "R6 data beats remote");
      probe(29'h1ABCDE00, 1, 1, 0, "R6 equal refused");

      // R5 rejection
      push_frame(29'h010, 0, 0, 1, 4'd2, 64'h0, 8'd200, 0, 0, 0, 0, "R5 error frame");
      push_frame(29'h010, 0, 0, 0, 4'd9, 64'h0, 8'd200, 0, 0, 0, 0, "R5 dlc 9");
      push_frame(29'h050, 0, 0, 0, 4'd2, 64'h0, 8'd200, 0, 1, 1, 0, "R5 slot0 still free");
      push_frame(29'h060, 0, 0, 0, 4'd2, 64'h0, 8'd200, 0, 0, 1, 2, "R2 F");

      // R9 deadline
      @(negedge clk);
      now = 8'd30;
      @(negedge clk); #1;
      chk("R9 abort B", 64'(mb_abort), 64'(3'b010));
      chk("R9 req others", 64'(mb_req), 64'(3'b101));
      chk("R9 timeout count", 64'(cnt_timeout), 1);
      repeat (3) @(negedge clk);
      #1 chk("R9 counted once", 64'(cnt_timeout), 1);

      // R10 bus error
      @(negedge clk);
      bus_lec = 3'd3;
      #1 chk("R10 lec_clear", 64'(lec_clear), 1);
      @(posedge clk);
      #1 bus_lec = 3'd0;
      @(negedge clk); #1;
      chk("R10 abort E", 64'(mb_abort), 64'(3'b011));
      chk("R10 F kept", 64'(mb_req), 64'(3'b100));
      chk("R10 abort count", 64'(cnt_abort), 1);

      // R7 failure completion
      finish_mb(3'b100, 3'b000);
      @(negedge clk); #1;
      chk("R7 no success on fail", 64'(cnt_success), 2);
      chk("R7 slot2 freed", 64'(mb_req), 0);
      probe(29'h7FF, 0, 1, 1, "R11 aborted ignored");
      finish_mb(3'b011, 3'b000);
      @(negedge clk); #1;
      chk("R9 abort released", 64'(mb_abort), 0);
      chk("R9 no success", 64'(cnt_success), 2);
      now = 8'd0;

      // random phase
      succ_exp = 8'd2;
      for (int it = 0; it < 150; it++) begin
         int n;
         logic [31:0] key [3];
         logic [31:0] word [3];
         n = 1 + int'($urandom % 3);
         for (int k = 0; k < n; k++) begin
            logic [28:0] id;
            logic ext, rtr;
            id  = 29'($urandom);
            ext = 1'($urandom);
            rtr = 1'($urandom);
            word[k] = exp_word(id, ext, rtr);
            key[k]  = exp_key(word[k]);
            push_frame(id, ext, rtr, 0, 4'($urandom % 9), {$urandom, $urandom}, 8'd255,
                       0, 0, 1, 2'(k), "R2 random");
         end
         @(negedge clk);
         @(negedge clk); #1;
         for (int k = 0; k < n; k++)
            chk("R3 random word", 64'(mb_idword[k*32 +: 32]), 64'(word[k] | 32'd1));
         for (int j = 0; j < 4; j++) begin
            logic [28:0] cid;
            logic cext, crtr, exp;
            logic [31:0] ck;
            cid  = (j == 0) ? word[0][31:3] : 29'($urandom);
            cext = (j == 0) ? word[0][2] : 1'($urandom);
            crtr = 1'($urandom);
            ck   = exp_key(exp_word(cid, cext, crtr));
            exp  = (n == 3) ? 1'b0 : 1'b1;
            for (int k = 0; k < n; k++) if (!(ck < key[k])) exp = 1'b0;
            probe(cid, cext, crtr, exp, "R6 random");
         end
         finish_mb(3'((1 << n) - 1), 3'((1 << n) - 1));
         succ_exp = succ_exp + 8'(n);
         @(negedge clk); #1;
         chk("R7 random success", 64'(cnt_success), 64'(succ_exp));
         chk("R7 random freed", 64'(mb_req), 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule